// File: doc/BRIEF.md
# Mode-Checked Crossbar Switch Fabric

This block is a single-stage switch that forwards data words from `NUM_IN` input ports to `NUM_OUT` output ports. A crosspoint matrix, held in the block, decides which input drives each output. An external controller loads the whole matrix in one write. The block checks every write against the rules of the active connection mode. It refuses an illegal write and raises an error flag instead.

The block has two connection modes. In fan-out mode, one input may feed several outputs, for example one requester reaching several memory banks. In paired mode, each input and each output takes part in at most one connection, so the matrix describes a permutation. Every output is registered, so every input-to-output path has the same single-cycle latency. When the mode changes, every crosspoint opens.

Top module: `xbar_fabric`

## Requirements
- R1: While reset is held, and in the first cycle after it, every `out_data_o` lane is zero, every `out_valid_o` bit is low and `cfg_err_o` is low. The mode register starts in fan-out mode (`mode_i` = 0).
- R2: Bit `o*NUM_IN + i` of `cfg_mat_i` closes the crosspoint from input `i` to output `o`. In either mode, a write that sets more than one bit for the same output is rejected.
- R3: In fan-out mode (`mode_i` = 0), a write that sets several bits for the same input is accepted. That input then appears on each of those outputs.
- R4: In paired mode (`mode_i` = 1), a write that sets more than one bit for the same input is rejected. Any write that sets at most one bit per input and per output, which includes every full permutation, is accepted.
- R5: With output `o` connected to input `i`, the data and valid presented on input `i` at clock edge k appear on output `o` after edge k. This holds for every connected pair.
- R6: A rejected write leaves the stored matrix unchanged. `cfg_err_o` is high for exactly the one cycle after that write's edge. An accepted write takes effect on data sampled from the next edge onward.
- R7: An output with no closed crosspoint drives zero data and a low valid bit one cycle later.
- R8: When `mode_i` differs from the stored mode at a clock edge, the matrix is cleared to all open and the new mode is stored. A configuration write in that same cycle is discarded, and no error is flagged.
- R9: The valid bit of a connected output equals the valid bit of its input one cycle earlier. The data is forwarded whether or not that input is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Connection mode: 0 fan-out, 1 paired |
| cfg_wr_i | input | 1 | Load `cfg_mat_i` as the new matrix |
| cfg_mat_i | input | NUM_IN*NUM_OUT | Requested crosspoint matrix, bit o*NUM_IN+i |
| in_data_i | input | NUM_IN*DW | Input data words, lane i at bits i*DW |
| in_valid_i | input | NUM_IN | Input valid bits |
| out_data_o | output | NUM_OUT*DW | Output data words, lane o at bits o*DW |
| out_valid_o | output | NUM_OUT | Output valid bits |
| cfg_err_o | output | 1 | One-cycle pulse after a rejected write |

## Verification
The assertions take only one thing for granted about the inputs: `mode_i` and `cfg_wr_i` are sampled cleanly at each edge. Every other input may take any value. Column and row exclusivity are then properties of the stored state, so they must hold no matter what matrix is requested. The stimulus deliberately requests illegal matrices in both modes, and it switches mode while a write is in flight. It drives only full-width 0/1 values, changing them half a period away from the sampling edge.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  typedef enum logic {
    XB_FANOUT = 1'b0,
    XB_PAIRED = 1'b1
  } xb_mode_e;
endpackage

// File: rtl/xbar_legal_check.sv
module xbar_legal_check
  import xbar_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 4
) (
  input  xb_mode_e                      mode,
  input  logic [NUM_IN*NUM_OUT-1:0]     mat,
  output logic                          legal
);
  logic [NUM_OUT-1:0] col_ok;
  logic [NUM_IN-1:0]  row_ok;

  // each output column: at most one closed crosspoint
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_col
    assign col_ok[o] = $onehot0(mat[o*NUM_IN +: NUM_IN]);
  end

  // each input row: gather its bits across all columns
  for (genvar i = 0; i < NUM_IN; i++) begin : g_row
    logic [NUM_OUT-1:0] row_bits;
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_bit
      assign row_bits[o] = mat[o*NUM_IN + i];
    end
    assign row_ok[i] = $onehot0(row_bits);
  end

  always_comb begin
    legal = &col_ok;
    if (mode == XB_PAIRED) legal = legal & (&row_ok);
  end
endmodule

// File: rtl/xbar_cfg_store.sv
module xbar_cfg_store
  import xbar_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  xb_mode_e                  mode_i,
  input  logic                      wr_i,
  input  logic [NUM_IN*NUM_OUT-1:0] mat_i,
  input  logic                      legal_i,
  output logic [NUM_IN*NUM_OUT-1:0] mat_o,
  output xb_mode_e                  mode_o,
  output logic                      err_o
);
  localparam int NXP = NUM_IN * NUM_OUT;

  logic [NXP-1:0] mat_q, mat_d;
  xb_mode_e       mode_q, mode_d;
  logic           err_q, err_d;
  logic           mat_en;
  logic           mode_chg;

  assign mode_chg = (mode_i != mode_q);

  always_comb begin
    mode_d = mode_i;
    mat_d  = mat_q;
    err_d  = 1'b0;
    mat_en = 1'b0;
    if (mode_chg) begin
      mat_d  = '0;
      mat_en = 1'b1;
    end else if (wr_i) begin
      if (legal_i) begin
        mat_d  = mat_i;
        mat_en = 1'b1;
      end else begin
        err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mat_q  <= '0;
      mode_q <= XB_FANOUT;
      err_q  <= 1'b0;
    end else begin
      if (mat_en) mat_q <= mat_d;
      mode_q <= mode_d;
      err_q  <= err_d;
    end
  end

  assign mat_o  = mat_q;
  assign mode_o = mode_q;
  assign err_o  = err_q;

  AST_KEEP_ON_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (mat_q == $past(mat_q))); // R6
  AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(wr_i)); // R6
  AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |-> (mat_q == '0)); // R8

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_acol
    AST_COL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mat_q[o*NUM_IN +: NUM_IN])); // R2
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_arow
    logic [NUM_OUT-1:0] row_q;
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_rb
      assign row_q[o] = mat_q[o*NUM_IN + i];
    end
    AST_ROW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == XB_PAIRED) |-> $onehot0(row_q)); // R4
  end
endmodule

// File: rtl/xbar_out_port.sv
module xbar_out_port #(
  parameter int NUM_IN = 4,
  parameter int DW     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_IN-1:0]    sel_col,
  input  logic [NUM_IN*DW-1:0] in_data,
  input  logic [NUM_IN-1:0]    in_valid,
  output logic [DW-1:0]        data_o,
  output logic                 valid_o
);
  logic [DW-1:0] data_q, data_d;
  logic          valid_q, valid_d;
  logic          en;

  // AND-OR selection; column is one-hot or empty
  always_comb begin
    data_d = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (sel_col[i]) data_d = data_d | in_data[i*DW +: DW];
    end
    valid_d = |(sel_col & in_valid);
    en      = (|sel_col) | valid_q | (|data_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else if (en) begin
      data_q  <= data_d;
      valid_q <= valid_d;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;

  AST_OPEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sel_col == '0) |-> (data_o == '0 && !valid_o)); // R7
  AST_VALID_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(|(sel_col & in_valid))); // R9
endmodule

// File: rtl/xbar_fabric.sv
module xbar_fabric
  import xbar_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 4,
  parameter int DW      = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        mode_i,
  input  logic                        cfg_wr_i,
  input  logic [NUM_IN*NUM_OUT-1:0]   cfg_mat_i,
  input  logic [NUM_IN*DW-1:0]        in_data_i,
  input  logic [NUM_IN-1:0]           in_valid_i,
  output logic [NUM_OUT*DW-1:0]       out_data_o,
  output logic [NUM_OUT-1:0]          out_valid_o,
  output logic                        cfg_err_o
);
  localparam int NXP = NUM_IN * NUM_OUT;

  xb_mode_e       mode_req;
  xb_mode_e       mode_cur;
  logic           legal;
  logic [NXP-1:0] mat_cur;

  assign mode_req = xb_mode_e'(mode_i);

  xbar_legal_check #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_check (
    .mode  (mode_req),
    .mat   (cfg_mat_i),
    .legal (legal)
  );

  xbar_cfg_store #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode_req),
    .wr_i    (cfg_wr_i),
    .mat_i   (cfg_mat_i),
    .legal_i (legal),
    .mat_o   (mat_cur),
    .mode_o  (mode_cur),
    .err_o   (cfg_err_o)
  );

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    xbar_out_port #(.NUM_IN(NUM_IN), .DW(DW)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_col  (mat_cur[o*NUM_IN +: NUM_IN]),
      .in_data  (in_data_i),
      .in_valid (in_valid_i),
      .data_o   (out_data_o[o*DW +: DW]),
      .valid_o  (out_valid_o[o])
    );
  end

  AST_ERR_PULSE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |-> (mode_cur == $past(mode_cur))); // R8
endmodule

// File: tb/xbar_fabric_tb.sv
module xbar_fabric_tb;
  localparam int NI = 4;
  localparam int NO = 4;
  localparam int DW = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             mode_i = 1'b0;
  logic             cfg_wr_i = 1'b0;
  logic [NI*NO-1:0] cfg_mat_i = '0;
  logic [NI*DW-1:0] in_data_i = '0;
  logic [NI-1:0]    in_valid_i = '0;
  logic [NO*DW-1:0] out_data_o;
  logic [NO-1:0]    out_valid_o;
  logic             cfg_err_o;

  always #2 clk = ~clk;

  xbar_fabric #(.NUM_IN(NI), .NUM_OUT(NO), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cfg_wr_i(cfg_wr_i),
    .cfg_mat_i(cfg_mat_i), .in_data_i(in_data_i), .in_valid_i(in_valid_i),
    .out_data_o(out_data_o), .out_valid_o(out_valid_o), .cfg_err_o(cfg_err_o)
  );

  int    nvec = 0;
  int    nfail = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  int       m_sel [NO];
  bit       m_mode;
  bit [7:0] e_data [NO];
  bit       e_val [NO];
  bit       e_err;

  function automatic bit legal_req(input bit md, input logic [NI*NO-1:0] m);
    for (int o = 0; o < NO; o++) begin
      int c = 0;
      for (int i = 0; i < NI; i++) if (m[o*NI+i]) c++;
      if (c > 1) return 1'b0;
    end
    if (md) begin
      for (int i = 0; i < NI; i++) begin
        int c = 0;
        for (int o = 0; o < NO; o++) if (m[o*NI+i]) c++;
        if (c > 1) return 1'b0;
      end
    end
    return 1'b1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int o = 0; o < NO; o++) begin m_sel[o] = -1; e_data[o] = 0; e_val[o] = 0; end
      m_mode = 0; e_err = 0;
    end else begin
      for (int o = 0; o < NO; o++) begin
        if (m_sel[o] >= 0) begin
          e_data[o] = in_data_i[m_sel[o]*DW +: DW];
          e_val[o]  = in_valid_i[m_sel[o]];
        end else begin
          e_data[o] = 0; e_val[o] = 0;
        end
      end
      e_err = 0;
      if (mode_i != m_mode) begin
        m_mode = mode_i;
        for (int o = 0; o < NO; o++) m_sel[o] = -1;
      end else if (cfg_wr_i) begin
        if (legal_req(m_mode, cfg_mat_i)) begin
          for (int o = 0; o < NO; o++) begin
            m_sel[o] = -1;
            for (int i = 0; i < NI; i++) if (cfg_mat_i[o*NI+i]) m_sel[o] = i;
          end
        end else e_err = 1;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      nvec++;
      for (int o = 0; o < NO; o++) begin
        if (out_data_o[o*DW +: DW] !== e_data[o] || out_valid_o[o] !== e_val[o]) begin
          nfail++;
          $display("FAIL %s out%0d: data=%h valid=%b expected data=%h valid=%b",
                   cur_req, o, out_data_o[o*DW +: DW], out_valid_o[o], e_data[o], e_val[o]);
        end
      end
      if (cfg_err_o !== e_err) begin
        nfail++;
        $display("FAIL %s err: got %b expected %b", cur_req, cfg_err_o, e_err);
      end
    end
  end

  function automatic logic [NI*NO-1:0] mk(input int s0, input int s1, input int s2, input int s3);
    logic [NI*NO-1:0] m = '0;
    if (s0 >= 0) m[0*NI+s0] = 1'b1;
    if (s1 >= 0) m[1*NI+s1] = 1'b1;
    if (s2 >= 0) m[2*NI+s2] = 1'b1;
    if (s3 >= 0) m[3*NI+s3] = 1'b1;
    return m;
  endfunction

  task automatic cyc(input bit wr, input logic [NI*NO-1:0] m, input bit md);
    @(negedge clk);
    cfg_wr_i   = wr;
    cfg_mat_i  = m;
    mode_i     = md;
    in_data_i  = {$urandom, $urandom};
    in_valid_i = NI'($urandom);
  endtask

  task automatic idle(input int n, input bit md);
    for (int k = 0; k < n; k++) cyc(1'b0, '0, md);
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      done = 1'b1;
      report();
    end
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2, 0);

    // R3 R5 R9: fan-out, input 0 to every output
    cur_req = "R3/R5/R9";
    cyc(1'b1, mk(0, 0, 0, 0), 0);
    idle(6, 0);
    cur_req = "R3/R5";
    cyc(1'b1, mk(2, 2, 1, 3), 0);
    idle(5, 0);

    // R2 R6: two inputs on output 0 rejected in fan-out mode
    cur_req = "R2/R6";
    cyc(1'b1, mk(2, 2, 1, 3) | (1 << 1), 0);
    idle(4, 0);
    cyc(1'b1, mk(2, 2, 1, 3) | (1 << 3), 0);
    cyc(1'b1, mk(-1, -1, -1, -1) | 16'h0011, 0);
    idle(3, 0);

    // R7: only output 1 connected
    cur_req = "R7";
    cyc(1'b1, mk(-1, 3, -1, -1), 0);
    idle(5, 0);

    // R8: mode change with concurrent write
    cur_req = "R8";
    cyc(1'b1, mk(0, 1, 2, 3), 1);
    idle(4, 1);

    // R4: paired mode, one input to two outputs rejected
    cur_req = "R4/R6";
    cyc(1'b1, mk(0, 0, -1, -1), 1);
    idle(3, 1);

    // R4 R5: permutations
    cur_req = "R4/R5";
    cyc(1'b1, mk(3, 2, 1, 0), 1);
    idle(5, 1);
    cyc(1'b1, mk(1, 2, 3, 0), 1);
    idle(5, 1);
    cyc(1'b1, mk(2, -1, 0, -1), 1);
    idle(4, 1);

    // R2: column clash in paired mode
    cur_req = "R2";
    cyc(1'b1, 16'h0003, 1);
    idle(3, 1);

    // R8: back to fan-out clears the permutation
    cur_req = "R8";
    cyc(1'b0, '0, 0);
    idle(4, 0);
    cur_req = "R3/R9";
    cyc(1'b1, mk(1, 1, 1, -1), 0);
    idle(20, 0);

    done = 1'b1;
    report();
  end
endmodule